// File: doc/BRIEF.md
# Audio master clock divider

The block derives an audio master clock and a once-per-sample frame strobe from a single fast reference clock. The reference runs at twice one of two base rates: 1024 times the sample rate (the 512fs family) or 768 times the sample rate (the 384fs family). A family select input says which one is present. A 3-bit ratio code then picks a power-of-two division. With the 512fs family the MCLK ratio runs from 512x down to 32x the sample rate. With the 384fs family it runs from 384x down to 48x. A 32x-family ratio therefore needs the 512fs family, and a 48x-family ratio needs the 384fs family.

The output toggles only while the run input is high and the gate input is low. A new family or ratio code is taken in at once while the divider is stopped. While it runs, a new setting waits for the end of the current frame, so the output never shows a shortened pulse. A code that the selected family cannot produce raises an error flag and holds the clock output low. The frame counter keeps running in that state.

Top module: `audio_mclk_div`

## Requirements
- R1: With fam384_i = 0 and ratio_code_i = k (0 to 4), mclk_o is a square wave with a period of 2^(k+1) clk_i cycles, giving 512/2^k times the sample rate. Each frame starts with the low half, which lasts 2^k cycles, followed by the high half of 2^k cycles.
- R2: With fam384_i = 1 and ratio_code_i = k (0 to 3), mclk_o has the same waveform as in R1, giving 384/2^k times the sample rate.
- R3: While the divider runs, frame_stb_o is high for exactly one cycle per frame. A frame is 1024 clk_i cycles in the 512fs family and 768 cycles in the 384fs family. The first strobe appears one full frame after the run starts, and the counter is at the start of a frame when the strobe is seen.
- R4: A change of fam384_i or ratio_code_i made while the divider runs has no effect on mclk_o, cfg_err_o or the frame length until the next frame boundary. At that boundary the new setting starts on a low phase.
- R5: When run_i is low, mclk_o and frame_stb_o are low from the next clock on, and the frame count restarts from zero.
- R6: When gate_i is high, mclk_o is held low from the next clock on, whatever the value of run_i.
- R7: cfg_err_o is high, and mclk_o is held low, when the active code is above 4, or when the active code is 4 with fam384_i = 1. Otherwise cfg_err_o is low.
- R8: While rst_ni is low, mclk_o, frame_stb_o and cfg_err_o are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock at twice the selected base rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Divider runs while high |
| gate_i | input | 1 | Forces the divider off while high |
| fam384_i | input | 1 | Family select: 0 selects the 512fs family, 1 selects the 384fs family |
| ratio_code_i | input | 3 | Power-of-two division code |
| mclk_o | output | 1 | Master clock output |
| frame_stb_o | output | 1 | One-cycle pulse at each frame boundary |
| cfg_err_o | output | 1 | Active setting cannot be produced |

## Verification
On every cycle, the embedded properties check four things. The output falls quiet the clock after a stop or a gate. An error flag never shows with the clock high. A strobe is always a single cycle that lines up with a counter restart. The active setting cannot change in the middle of a frame. The bench scenarios are needed to show the rest: the exact period and phase for each family and code, the frame lengths of 1024 and 768 cycles, and the moment a mid-frame change takes effect. A cycle-by-cycle reference model, built from the requirements, predicts each of these.

// File: rtl/amd_pkg.sv
package amd_pkg;

  localparam int unsigned CODE_W = 3;

  typedef struct packed {
    logic              fam384;
    logic [CODE_W-1:0] code;
  } div_cfg_t;

  // A code is usable when it does not exceed the deepest tap of its family.
  function automatic logic cfg_invalid(div_cfg_t c, int unsigned top_a, int unsigned top_b);
    int unsigned lim;
    lim = c.fam384 ? top_b : top_a;
    return (32'(c.code) > lim);
  endfunction

endpackage

// File: rtl/amd_frame_ctr.sv
module amd_frame_ctr #(
  parameter int unsigned FRAME_A = 1024,
  parameter int unsigned FRAME_B = 768,
  parameter int unsigned CNT_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fam384_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             wrap_o,
  output logic             stb_o
);

  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(FRAME_A - 1);
  localparam logic [CNT_W-1:0] LAST_B = CNT_W'(FRAME_B - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             stb_q, stb_d;
  logic [CNT_W-1:0] last;

  always_comb begin
    last   = fam384_i ? LAST_B : LAST_A;
    wrap_o = en_i && (cnt_q == last);
    if (!en_i || wrap_o) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
    stb_d  = wrap_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign cnt_nxt_o = cnt_d;
  assign stb_o     = stb_q;

  // R3: a strobe lasts one cycle and coincides with a counter restart
  a_r3_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  a_r3_stb_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> (cnt_q == '0));
  // R5: a stopped divider restarts its count
  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

endmodule

// File: rtl/amd_cfg_hold.sv
module amd_cfg_hold
  import amd_pkg::*;
#(
  parameter int unsigned TOP_A = 4,
  parameter int unsigned TOP_B = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wrap_i,
  input  logic              fam384_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              fam384_o,
  output logic [CODE_W-1:0] code_nxt_o,
  output logic              err_nxt_o,
  output logic              err_o
);

  div_cfg_t cfg_q, cfg_d;
  logic     err_q, err_d;
  logic     load;

  always_comb begin
    load  = !en_i || wrap_i;
    cfg_d = cfg_q;
    if (load) begin
      cfg_d.fam384 = fam384_i;
      cfg_d.code   = code_i;
    end
    err_d = cfg_invalid(cfg_d, TOP_A, TOP_B);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign fam384_o   = cfg_q.fam384;
  assign code_nxt_o = cfg_d.code;
  assign err_nxt_o  = err_d;
  assign err_o      = err_q;

  // R4: the active setting holds for the whole of a running frame
  a_r4_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_i) |=> ($stable(cfg_q) && $stable(err_q)));

endmodule

// File: rtl/amd_tap.sv
module amd_tap
  import amd_pkg::*;
#(
  parameter int unsigned CNT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              err_nxt_i,
  input  logic [CODE_W-1:0] code_nxt_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  output logic              mclk_o
);

  logic mclk_q, mclk_d;

  always_comb begin
    mclk_d = en_i && !err_nxt_i && cnt_nxt_i[code_nxt_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mclk_q <= 1'b0;
    else         mclk_q <= mclk_d;
  end

  assign mclk_o = mclk_q;

endmodule

// File: rtl/audio_mclk_div.sv
module audio_mclk_div
  import amd_pkg::*;
#(
  parameter int unsigned FRAME_A = 1024,
  parameter int unsigned FRAME_B = 768,
  parameter int unsigned TOP_A   = 4,
  parameter int unsigned TOP_B   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              gate_i,
  input  logic              fam384_i,
  input  logic [CODE_W-1:0] ratio_code_i,
  output logic              mclk_o,
  output logic              frame_stb_o,
  output logic              cfg_err_o
);

  localparam int unsigned FRAME_MAX = (FRAME_A > FRAME_B) ? FRAME_A : FRAME_B;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX);

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic              en;
  logic              wrap;
  logic              act_fam384;
  logic [CODE_W-1:0] code_nxt;
  logic              err_nxt;
  logic [CNT_W-1:0]  cnt_nxt;

  assign en = run_i && !gate_i;

  amd_frame_ctr #(
    .FRAME_A (FRAME_A),
    .FRAME_B (FRAME_B),
    .CNT_W   (CNT_W)
  ) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .en_i      (en),
    .fam384_i  (act_fam384),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap),
    .stb_o     (frame_stb_o)
  );

  amd_cfg_hold #(
    .TOP_A (TOP_A),
    .TOP_B (TOP_B)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .en_i       (en),
    .wrap_i     (wrap),
    .fam384_i   (fam384_i),
    .code_i     (ratio_code_i),
    .fam384_o   (act_fam384),
    .code_nxt_o (code_nxt),
    .err_nxt_o  (err_nxt),
    .err_o      (cfg_err_o)
  );

  amd_tap #(
    .CNT_W (CNT_W)
  ) u_tap (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_q),
    .en_i       (en),
    .err_nxt_i  (err_nxt),
    .code_nxt_i (code_nxt),
    .cnt_nxt_i  (cnt_nxt),
    .mclk_o     (mclk_o)
  );

  // R5: a stop silences clock and strobe on the next edge
  a_r5_stop_quiet: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !run_i |=> (!mclk_o && !frame_stb_o));
  // R6: the gate overrides run
  a_r6_gate_quiet: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    gate_i |=> !mclk_o);
  // R7: an unusable setting never drives the clock high
  a_r7_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    cfg_err_o |-> !mclk_o);
  // R8: outputs quiet during reset
  a_r8_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!mclk_o && !frame_stb_o && !cfg_err_o));

endmodule

// File: tb/audio_mclk_div_tb_top.sv
`timescale 1ns/1ps
module audio_mclk_div_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       run, gate, fam;
  logic [2:0] code;
  logic       mclk, stb, err;

  always #2.5 clk = ~clk;

  audio_mclk_div dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .run_i        (run),
    .gate_i       (gate),
    .fam384_i     (fam),
    .ratio_code_i (code),
    .mclk_o       (mclk),
    .frame_stb_o  (stb),
    .cfg_err_o    (err)
  );

  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  logic [2:0] q_val[$];
  string      q_tag[$];

  // requirement-level reference state
  int         m_ph = 0;
  logic       m_fam = 1'b0;
  logic [2:0] m_code = 3'd0;

  task automatic drive(input logic r, input logic g, input logic f,
                       input logic [2:0] c, input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      logic en, e_stb, e_err, e_mclk;
      int   len;
      @(negedge clk);
      run = r; gate = g; fam = f; code = c;
      en  = r && !g;
      len = m_fam ? 768 : 1024;
      e_stb = 1'b0;
      if (!en) begin
        m_ph = 0; m_fam = f; m_code = c;
      end else if (m_ph == len - 1) begin
        m_ph = 0; m_fam = f; m_code = c; e_stb = 1'b1;
      end else begin
        m_ph = m_ph + 1;
      end
      e_err  = (m_code > 3'd4) || (m_fam && m_code == 3'd4);
      e_mclk = en && !e_err && (((m_ph >> m_code) % 2) == 1);
      q_val.push_back({e_mclk, e_stb, e_err});
      q_tag.push_back(tag);
    end
  endtask

  // monitor: compare one predicted item per clock, 1 ns after the edge
  always @(posedge clk) begin
    logic [2:0] v;
    string      t;
    #1;
    if (q_val.size() > 0) begin
      v = q_val.pop_front();
      t = q_tag.pop_front();
      checks++;
      if ({mclk, stb, err} !== v) begin
        failures++;
        $display("FAIL %s: {mclk,stb,err} actual=%b expected=%b at %0t", t, {mclk, stb, err}, v, $time);
      end
    end
  end

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; gate = 1'b0; fam = 1'b0; code = 3'd0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if ({mclk, stb, err} !== 3'b000) begin
      failures++;
      $display("FAIL R8: reset outputs actual=%b expected=000", {mclk, stb, err});
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int k = 0; k <= 4; k++) begin
      drive(1, 0, 0, 3'(k), "R1", 1100);
      drive(0, 0, 0, 3'(k), "R5", 10);
    end
    for (int k = 0; k <= 3; k++) begin
      drive(1, 0, 1, 3'(k), "R2", 800);
      drive(0, 0, 1, 3'(k), "R5", 6);
    end
    drive(1, 0, 0, 3'd2, "R3", 2100);
    drive(0, 0, 1, 3'd2, "R3", 3);
    drive(1, 0, 1, 3'd2, "R3", 1600);
    drive(0, 0, 0, 3'd1, "R5", 4);

    drive(1, 0, 0, 3'd1, "R4", 300);
    drive(1, 0, 0, 3'd3, "R4", 1200);
    drive(1, 0, 1, 3'd2, "R4", 200);
    drive(1, 0, 1, 3'd2, "R4", 1000);
    drive(0, 0, 0, 3'd0, "R5", 5);

    drive(1, 1, 0, 3'd2, "R6", 100);
    drive(1, 0, 0, 3'd2, "R6", 300);
    drive(1, 1, 0, 3'd2, "R6", 50);
    drive(0, 1, 0, 3'd2, "R6", 5);

    drive(1, 0, 1, 3'd4, "R7", 800);
    drive(0, 0, 1, 3'd4, "R7", 5);
    drive(1, 0, 0, 3'd6, "R7", 1100);
    drive(1, 0, 0, 3'd4, "R7", 1100);
    drive(0, 0, 0, 3'd0, "R7", 5);

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run not finished actual=hung expected=done");
      finish_run();
    end
  end

endmodule